// File: doc/BRIEF.md
# Committed Stream Crosspoint Switch

This block routes up to eight video streams onto up to eight output streams. Every output picks exactly one source input, and one input can feed several outputs at once. Every stream port carries a valid/ready handshake with a data word, an end-of-frame flag (`last`) and a start-of-frame flag (`user`). Routing comes from a small register file behind a simple memory-mapped write/read port. Software programs a staged copy of the per-input modes and per-output selections. A commit write then asks the block to move that staged copy into the live routing.

A routing change is never applied in the middle of a frame. Once a switch starts, outputs that are idle stop admitting new frames. Outputs that are part-way through a frame run on until their end-of-frame beat has been accepted. At that point the staged settings are loaded. After the load, each output passes nothing until its source offers a start-of-frame beat. Non-start beats that arrive in that window are accepted and discarded. A commit that arrives while a switch is running is held and starts as soon as that switch completes. A build option can freeze the control registers.

Top module: `strmx_switch`

## Requirements
- R1: After reset, every input and every output is disabled. The status register (0x10) reads 0x1. Addresses that map to no register read as zero.
- R2: An input whose active mode code is 00 or 10 holds its ready low, and its data reaches no output.
- R3: An input whose active mode code is 11 holds its ready high, and its data reaches no output.
- R4: An input whose active mode code is 01 raises ready only when at least one active output selects it. When no active output selects it, its ready stays low.
- R5: The control word of output j sits at 0x80+4j, with bit 8 as the enable and bits [7:0] as the source index. An enabled output with an in-range source presents that source's valid, data, last and user. The mode word of input i sits at 0x40+4i, with the mode code in bits [1:0].
- R6: An output that is disabled, or whose source index is N_IN or greater, never raises valid.
- R7: When several outputs select one input, valid and data go to all of them. The input's ready is the AND of their ready contributions.
- R8: Control writes land only in the staged copy and leave the live routing unchanged. Writing 1 to bit 0 of 0x14 commits. Status bit 1 (pending) rises on any control write. It clears when a switch actually starts.
- R9: Status bit 0 reads 0 while a switch runs. A switch completes only after every output has finished its frame in progress. Routing never changes in the middle of a frame, and no idle output starts a new frame during the switch.
- R10: A commit written while a switch runs is queued. It starts in the cycle that the running switch completes, loading the staged settings present at that time.
- R11: After a switch, each output forwards nothing until its source presents a beat with `user` set. Beats without `user` that arrive before then are accepted from the input and discarded.
- R12: Address 0x00 reads the identifier 0x5C0A_7E11. Address 0x04 reads N_IN and address 0x08 reads N_OUT. The control addresses read back the staged values.
- R13: With CTRL_LOCK set, writes to the input and output control registers are ignored, and pending never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| s_valid | input | N_IN | Per-input beat valid |
| s_ready | output | N_IN | Per-input ready |
| s_data | input | N_IN*DATA_W | Per-input data, input i at [i*DATA_W +: DATA_W] |
| s_last | input | N_IN | Per-input end-of-frame flag |
| s_user | input | N_IN | Per-input start-of-frame flag |
| m_valid | output | N_OUT | Per-output beat valid |
| m_ready | input | N_OUT | Per-output ready |
| m_data | output | N_OUT*DATA_W | Per-output data, output j at [j*DATA_W +: DATA_W] |
| m_last | output | N_OUT | Per-output end-of-frame flag |
| m_user | output | N_OUT | Per-output start-of-frame flag |

## Verification
The assertions assume that `last` on an input closes every frame that input opens. They also assume that each input holds its word steady while it waits for ready. If either assumption failed, an output could stay mid-frame forever and a switch would never complete. The stimulus either sends single-beat frames with `last` set, or it opens one long frame and later closes it with an explicit end-of-frame beat. Register writes come no more than one per cycle and never overlap a read, so the staged and live sets can be checked apart.

// File: rtl/strmx_pkg.sv
// Package: shared encodings, register offsets and types for the stream switch.
// Assumes byte addresses, one 32-bit register per 4-byte slot.
package strmx_pkg;

    // Per-input mode code held in bits [1:0] of an input control word
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_PASS = 2'b01,
        MODE_OFFB = 2'b10,
        MODE_DROP = 2'b11
    } in_mode_e;

    // Per-output control word: enable in bit 8, source index in [7:0]
    typedef struct packed {
        logic       en;
        logic [7:0] src;
    } out_cfg_t;

    localparam int unsigned   SRC_W        = 8;
    localparam int unsigned   ADR_ID       = 'h00;
    localparam int unsigned   ADR_NIN      = 'h04;
    localparam int unsigned   ADR_NOUT     = 'h08;
    localparam int unsigned   ADR_STAT     = 'h10;
    localparam int unsigned   ADR_COMMIT   = 'h14;
    localparam int unsigned   ADR_IN_BASE  = 'h40;
    localparam int unsigned   ADR_OUT_BASE = 'h80;
    localparam logic [31:0]   ID_VALUE     = 32'h5C0A_7E11;

endpackage

// File: rtl/strmx_regs.sv
// Module: register file, staged/live routing sets and commit sequencing.
// Assumes at most one write per cycle; reads are combinational on cfg_addr.
// A switch starts on commit (or from a queued commit) and completes when the
// frame tracker reports every output idle; the snapshot then becomes live.
module strmx_regs
    import strmx_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 4,
    parameter int ADDR_W    = 8,
    parameter bit CTRL_LOCK = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic                    frames_idle,
    output in_mode_e [N_IN-1:0]     act_mode,
    output out_cfg_t [N_OUT-1:0]    act_out,
    output logic                    switching,
    output logic                    pending,
    output logic                    load
);

    in_mode_e [N_IN-1:0]  shd_mode;
    in_mode_e [N_IN-1:0]  snap_mode;
    out_cfg_t [N_OUT-1:0] shd_out;
    out_cfg_t [N_OUT-1:0] snap_out;
    logic [N_IN-1:0]      hit_in;
    logic [N_OUT-1:0]     hit_out;
    logic                 commit_wr;
    logic                 ctrl_wr;
    logic                 start;
    logic                 queued;

    // Decode writes to each input control slot
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign hit_in[i] = !CTRL_LOCK && cfg_wr &&
                           (cfg_addr == ADDR_W'(ADR_IN_BASE + 4 * i));

        // Staged input mode register
        always_ff @(posedge clk) begin
            if (!rst_n)
                shd_mode[i] <= MODE_OFF;
            else if (hit_in[i])
                shd_mode[i] <= in_mode_e'(cfg_wdata[1:0]);
        end
    end

    // Decode writes to each output control slot
    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        assign hit_out[j] = !CTRL_LOCK && cfg_wr &&
                            (cfg_addr == ADDR_W'(ADR_OUT_BASE + 4 * j));

        // Staged output selection register
        always_ff @(posedge clk) begin
            if (!rst_n)
                shd_out[j] <= '0;
            else if (hit_out[j])
                shd_out[j] <= out_cfg_t'(cfg_wdata[8:0]);
        end
    end

    assign commit_wr = cfg_wr && cfg_wdata[0] && (cfg_addr == ADDR_W'(ADR_COMMIT));
    assign ctrl_wr   = (|hit_in) || (|hit_out);
    assign load      = switching && frames_idle;
    assign start     = (commit_wr && (!switching || load)) || (load && queued);

    // Switch sequencing: running flag, queued commit and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            switching <= 1'b0;
            queued    <= 1'b0;
            pending   <= 1'b0;
        end else begin
            if (start)
                switching <= 1'b1;
            else if (load)
                switching <= 1'b0;

            if (commit_wr && switching && !load)
                queued <= 1'b1;
            else if (load)
                queued <= 1'b0;

            if (ctrl_wr)
                pending <= 1'b1;
            else if (start)
                pending <= 1'b0;
        end
    end

    // Snapshot of the staged set taken when a switch starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_mode <= '0;
            snap_out  <= '0;
        end else if (start) begin
            snap_mode <= shd_mode;
            snap_out  <= shd_out;
        end
    end

    // Live routing, loaded only when a switch completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mode <= '0;
            act_out  <= '0;
        end else if (load) begin
            act_mode <= snap_mode;
            act_out  <= snap_out;
        end
    end

    // Read data multiplexer; unmapped addresses return zero
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_W'(ADR_ID))
            cfg_rdata = ID_VALUE;
        if (cfg_addr == ADDR_W'(ADR_NIN))
            cfg_rdata = 32'(N_IN);
        if (cfg_addr == ADDR_W'(ADR_NOUT))
            cfg_rdata = 32'(N_OUT);
        if (cfg_addr == ADDR_W'(ADR_STAT))
            cfg_rdata = {30'b0, pending, !switching};
        for (int i = 0; i < N_IN; i++)
            if (cfg_addr == ADDR_W'(ADR_IN_BASE + 4 * i))
                cfg_rdata = {30'b0, shd_mode[i]};
        for (int j = 0; j < N_OUT; j++)
            if (cfg_addr == ADDR_W'(ADR_OUT_BASE + 4 * j))
                cfg_rdata = {23'b0, shd_out[j]};
    end

endmodule

// File: rtl/strmx_frame_trk.sv
// Module: per-output frame tracking.
// busy  : a frame has started on the output and its last beat is not yet taken.
// synced: a start-of-frame beat has passed since the last routing load.
// Assumes only start-of-frame beats can pass an unsynced output.
module strmx_frame_trk #(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] m_hs,
    input  logic [N_OUT-1:0] m_last,
    input  logic             load,
    output logic [N_OUT-1:0] busy,
    output logic [N_OUT-1:0] synced,
    output logic             frames_idle
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_trk
        // Track the open frame on output j
        always_ff @(posedge clk) begin
            if (!rst_n)
                busy[j] <= 1'b0;
            else if (m_hs[j])
                busy[j] <= !m_last[j];
        end

        // Track frame alignment of output j after each routing load
        always_ff @(posedge clk) begin
            if (!rst_n)
                synced[j] <= 1'b0;
            else if (load)
                synced[j] <= 1'b0;
            else if (m_hs[j])
                synced[j] <= 1'b1;
        end
    end

    assign frames_idle = ~|busy;

endmodule

// File: rtl/strmx_route.sv
// Module: combinational crosspoint: output selection and input ready merge.
// Assumes the live routing is steady while any output is mid-frame.
// While a switch runs, only outputs that are mid-frame may move beats.
module strmx_route
    import strmx_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int DATA_W = 16
) (
    input  logic [N_IN-1:0]         s_valid,
    output logic [N_IN-1:0]         s_ready,
    input  logic [N_IN*DATA_W-1:0]  s_data,
    input  logic [N_IN-1:0]         s_last,
    input  logic [N_IN-1:0]         s_user,
    output logic [N_OUT-1:0]        m_valid,
    input  logic [N_OUT-1:0]        m_ready,
    output logic [N_OUT*DATA_W-1:0] m_data,
    output logic [N_OUT-1:0]        m_last,
    output logic [N_OUT-1:0]        m_user,
    input  in_mode_e [N_IN-1:0]     act_mode,
    input  out_cfg_t [N_OUT-1:0]    act_out,
    input  logic                    switching,
    input  logic [N_OUT-1:0]        busy,
    input  logic [N_OUT-1:0]        synced
);

    localparam int IDX_W = $clog2(N_IN);

    logic [N_OUT-1:0]            sel_ok;
    logic [N_OUT-1:0][IDX_W-1:0] sel;
    logic [N_OUT-1:0]            admit;
    logic [N_OUT-1:0]            gate;
    logic [N_OUT-1:0]            c_rdy;

    // Output side: pick the source, apply gating and frame alignment
    always_comb begin
        m_valid = '0;
        m_data  = '0;
        m_last  = '0;
        m_user  = '0;
        for (int j = 0; j < N_OUT; j++) begin
            sel_ok[j] = act_out[j].en && (act_out[j].src < SRC_W'(N_IN));
            sel[j]    = act_out[j].src[IDX_W-1:0];
            gate[j]   = !switching || busy[j];
            admit[j]  = synced[j] || s_user[sel[j]];
            m_valid[j] = sel_ok[j] && gate[j] && admit[j] &&
                         (act_mode[sel[j]] == MODE_PASS) && s_valid[sel[j]];
            m_data[j*DATA_W +: DATA_W] = s_data[int'(sel[j])*DATA_W +: DATA_W];
            m_last[j] = s_last[sel[j]];
            m_user[j] = s_user[sel[j]];
            c_rdy[j]  = gate[j] && (admit[j] ? m_ready[j] : 1'b1);
        end
    end

    // Input side: merge ready over every output that selects the input
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            logic any_sel;
            logic all_rdy;
            any_sel = 1'b0;
            all_rdy = 1'b1;
            for (int j = 0; j < N_OUT; j++) begin
                if (sel_ok[j] && (sel[j] == IDX_W'(i))) begin
                    any_sel = 1'b1;
                    all_rdy = all_rdy && c_rdy[j];
                end
            end
            case (act_mode[i])
                MODE_DROP: s_ready[i] = 1'b1;
                MODE_PASS: s_ready[i] = any_sel && all_rdy;
                default:   s_ready[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/strmx_switch.sv
// Module: top of the committed stream crosspoint switch.
// Assumes 2 <= N_IN <= 8 and 1 <= N_OUT <= 8; single clock, synchronous
// active-low reset. Stream paths are combinational from input to output.
module strmx_switch
    import strmx_pkg::*;
#(
    parameter int N_IN      = 4,
    parameter int N_OUT     = 4,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8,
    parameter bit CTRL_LOCK = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic [N_IN-1:0]         s_valid,
    output logic [N_IN-1:0]         s_ready,
    input  logic [N_IN*DATA_W-1:0]  s_data,
    input  logic [N_IN-1:0]         s_last,
    input  logic [N_IN-1:0]         s_user,
    output logic [N_OUT-1:0]        m_valid,
    input  logic [N_OUT-1:0]        m_ready,
    output logic [N_OUT*DATA_W-1:0] m_data,
    output logic [N_OUT-1:0]        m_last,
    output logic [N_OUT-1:0]        m_user
);

    in_mode_e [N_IN-1:0]  act_mode;
    out_cfg_t [N_OUT-1:0] act_out;
    logic                 switching;
    logic                 pending;
    logic                 load;
    logic                 frames_idle;
    logic [N_OUT-1:0]     busy;
    logic [N_OUT-1:0]     synced;

    strmx_regs #(
        .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .CTRL_LOCK(CTRL_LOCK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frames_idle(frames_idle),
        .act_mode(act_mode), .act_out(act_out), .switching(switching),
        .pending(pending), .load(load)
    );

    strmx_frame_trk #(.N_OUT(N_OUT)) u_trk (
        .clk(clk), .rst_n(rst_n), .m_hs(m_valid & m_ready), .m_last(m_last),
        .load(load), .busy(busy), .synced(synced), .frames_idle(frames_idle)
    );

    strmx_route #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W)) u_route (
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .s_user(s_user), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_last(m_last), .m_user(m_user), .act_mode(act_mode), .act_out(act_out),
        .switching(switching), .busy(busy), .synced(synced)
    );

endmodule

// File: rtl/strmx_switch_chk.sv
// Module: assertion checker bound into strmx_switch.
// Assumes inputs close each frame with last and hold data while stalled.
module strmx_switch_chk
    import strmx_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IN-1:0]         s_ready,
    input  logic [N_IN*DATA_W-1:0]  s_data,
    input  logic [N_OUT-1:0]        m_valid,
    input  logic [N_OUT*DATA_W-1:0] m_data,
    input  in_mode_e [N_IN-1:0]     act_mode,
    input  out_cfg_t [N_OUT-1:0]    act_out,
    input  logic                    switching,
    input  logic                    pending,
    input  logic [N_OUT-1:0]        busy
);

    localparam int IDX_W = $clog2(N_IN);

    logic [N_OUT-1:0]             route_on;
    logic [N_IN-1:0]              chosen;
    logic [N_OUT*DATA_W-1:0]      exp_data;

    // Independent view of which outputs are live and which inputs are chosen
    always_comb begin
        chosen   = '0;
        exp_data = '0;
        for (int j = 0; j < N_OUT; j++) begin
            route_on[j] = act_out[j].en && (int'(act_out[j].src) < N_IN);
            if (route_on[j]) begin
                chosen[act_out[j].src[IDX_W-1:0]] = 1'b1;
                exp_data[j*DATA_W +: DATA_W] =
                    s_data[int'(act_out[j].src[IDX_W-1:0])*DATA_W +: DATA_W];
            end
        end
    end

    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switching) |-> !pending); // R8

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[i] == MODE_OFF || act_mode[i] == MODE_OFFB) |-> !s_ready[i]); // R2
        AST_DROP_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[i] == MODE_DROP) |-> s_ready[i]); // R3
        AST_UNSEL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (act_mode[i] == MODE_PASS && !chosen[i]) |-> !s_ready[i]); // R4
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !route_on[j] |-> !m_valid[j]); // R6
        AST_BCAST_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            m_valid[j] |-> (m_data[j*DATA_W +: DATA_W] == exp_data[j*DATA_W +: DATA_W])); // R7
        AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            busy[j] |=> $stable(act_out[j])); // R9
        AST_NO_NEW_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
            (switching && !busy[j]) |-> !m_valid[j]); // R9
    end

endmodule

bind strmx_switch strmx_switch_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_data(m_data), .act_mode(act_mode), .act_out(act_out),
    .switching(switching), .pending(pending), .busy(busy)
);

// File: tb/sim_strmx_switch.sv
`timescale 1ns/1ps
module sim_strmx_switch;
    localparam int NI = 4;
    localparam int NO = 4;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 1'b0;
    logic [7:0]      cfg_addr = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [31:0]     cfg_rdata, cfg_rdata1;
    logic [NI-1:0]   s_valid = '0, s_last = '0, s_user = '0;
    logic [NI-1:0]   s_ready, s_ready1;
    logic [NI*W-1:0] s_data = '0;
    logic [NO-1:0]   m_ready = '0;
    logic [NO-1:0]   m_valid, m_last, m_user, m_valid1, m_last1, m_user1;
    logic [NO*W-1:0] m_data, m_data1;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    strmx_switch #(.N_IN(NI), .N_OUT(NO), .DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .s_valid(s_valid),
        .s_ready(s_ready), .s_data(s_data), .s_last(s_last), .s_user(s_user),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .m_user(m_user));

    strmx_switch #(.N_IN(NI), .N_OUT(NO), .DATA_W(W), .CTRL_LOCK(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata1), .s_valid(s_valid),
        .s_ready(s_ready1), .s_data(s_data), .s_last(s_last), .s_user(s_user),
        .m_valid(m_valid1), .m_ready(m_ready), .m_data(m_data1), .m_last(m_last1),
        .m_user(m_user1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a; #1; d = cfg_rdata;
    endtask

    task automatic set_in(input int i, input int code);
        wr(8'(8'h40 + 4 * i), 32'(code));
    endtask

    task automatic set_out(input int j, input bit en, input int src);
        wr(8'(8'h80 + 4 * j), {23'b0, en, 8'(src)});
    endtask

    task automatic commit_wait();
        wr(8'h14, 32'h1);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [W-1:0] dval(input int i, input int s);
        return W'(16'h1000 * (i + 1) + s);
    endfunction

    task automatic set_data(input int s);
        for (int i = 0; i < NI; i++) s_data[i*W +: W] = dval(i, s);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R12: reset state and parameter registers
        rd(8'h00, rv); chk("R12 id", rv, 32'h5C0A_7E11);
        rd(8'h04, rv); chk("R12 nin", rv, NI);
        rd(8'h08, rv); chk("R12 nout", rv, NO);
        rd(8'h10, rv); chk("R1 status", rv, 32'h1);
        rd(8'h0C, rv); chk("R1 unused", rv, 32'h0);
        rd(8'h84, rv); chk("R1 out1 reset", rv, 32'h0);
        s_valid = '1; s_user = '1; s_last = '1; m_ready = '1; set_data(0); #1;
        chk("R1 ready", 32'(s_ready), 32'h0);
        chk("R1 valid", 32'(m_valid), 32'h0);

        // R8: staged writes have no effect until commit
        set_in(0, 1);
        set_out(0, 1, 0);
        rd(8'h10, rv); chk("R8 pending", rv, 32'h3);
        rd(8'h40, rv); chk("R12 in0 readback", rv, 32'h1);
        rd(8'h80, rv); chk("R12 out0 readback", rv, 32'h100);
        chk("R8 no effect", 32'(m_valid[0]), 32'h0);
        commit_wait();
        rd(8'h10, rv); chk("R8 after commit", rv, 32'h1);
        chk("R5 valid after commit", 32'(m_valid[0]), 32'h1);

        // R2 / R3 / R4: sweep of mode codes on input 0, input 1 enabled but unselected
        for (int code = 0; code < 4; code++) begin
            set_in(0, code);
            set_in(1, 1);
            commit_wait();
            #1;
            chk("R2 R3 R4 ready", 32'(s_ready[0]), 32'((code == 1) || (code == 3)));
            chk("R2 R3 valid", 32'(m_valid[0]), 32'(code == 1));
            chk("R4 unselected", 32'(s_ready[1]), 32'h0);
        end

        // R5 / R6: routing sweep over in-range and out-of-range sources
        for (int i = 0; i < NI; i++) set_in(i, 1);
        for (int s = 0; s < NI + 2; s++) begin
            for (int j = 0; j < NO; j++) set_out(j, 1'b1, (s + j) % (NI + 2));
            commit_wait();
            set_data(s); s_last = '1; #1;
            for (int j = 0; j < NO; j++) begin
                int src;
                src = (s + j) % (NI + 2);
                chk("R5 R6 valid", 32'(m_valid[j]), 32'(src < NI));
                if (src < NI) begin
                    chk("R5 data", 32'(m_data[j*W +: W]), 32'(dval(src, s)));
                    chk("R5 last", 32'(m_last[j]), 32'h1);
                end
            end
        end
        set_out(2, 1'b0, 2);
        commit_wait(); #1;
        chk("R6 disabled", 32'(m_valid[2]), 32'h0);

        // R7: broadcast and ready merge
        set_out(0, 1, 2); set_out(1, 1, 2); set_out(2, 0, 0); set_out(3, 0, 0);
        commit_wait();
        m_ready = 4'b0001; #1;
        chk("R7 valid both", 32'(m_valid[1:0]), 32'h3);
        chk("R7 data copy", 32'(m_data[W +: W]), 32'(dval(2, NI + 1)));
        chk("R7 ready and", 32'(s_ready[2]), 32'h0);
        m_ready = 4'b0011; #1;
        chk("R7 ready all", 32'(s_ready[2]), 32'h1);

        // R9 / R10: switch waits for the open frame; queued commit
        s_valid = '0; m_ready = '1;
        set_out(0, 1, 0); set_out(1, 0, 0);
        commit_wait();
        @(negedge clk);
        s_valid = 4'b0001; s_user = 4'b0001; s_last = '0;
        @(negedge clk);
        s_valid = '0; s_user = '0;
        set_out(0, 1, 1);
        wr(8'h14, 32'h1);
        rd(8'h10, rv); chk("R9 running", rv, 32'h0);
        repeat (4) @(negedge clk);
        rd(8'h10, rv); chk("R9 still running", rv, 32'h0);
        s_valid = 4'b0001; set_data(7); #1;
        chk("R9 old route valid", 32'(m_valid[0]), 32'h1);
        chk("R9 old route data", 32'(m_data[W-1:0]), 32'(dval(0, 7)));
        s_valid = '0;
        set_out(1, 1, 1);
        rd(8'h10, rv); chk("R8 pending during run", rv, 32'h2);
        wr(8'h14, 32'h1);
        rd(8'h10, rv); chk("R10 queued", rv, 32'h2);
        s_valid = 4'b0001; s_last = 4'b0001;
        @(negedge clk);
        s_valid = '0; s_last = '0;
        rd(8'h10, rv); chk("R10 before restart", rv, 32'h2);
        @(negedge clk);
        rd(8'h10, rv); chk("R10 restarted", rv, 32'h0);
        @(negedge clk);
        rd(8'h10, rv); chk("R9 complete", rv, 32'h1);

        // R11: new mapping waits for start-of-frame
        s_valid = 4'b0010; s_user = '0; s_last = '1; set_data(9); #1;
        chk("R11 blocked", 32'(m_valid[1:0]), 32'h0);
        chk("R11 dropped", 32'(s_ready[1]), 32'h1);
        s_user = 4'b0010; #1;
        chk("R11 sof valid", 32'(m_valid[1:0]), 32'h3);
        chk("R11 sof data", 32'(m_data[W-1:0]), 32'(dval(1, 9)));
        @(negedge clk);
        s_user = '0; #1;
        chk("R11 synced", 32'(m_valid[0]), 32'h1);
        s_valid = '0;

        // R13: locked instance ignored every control write
        cfg_addr = 8'h40; #1; chk("R13 in0", cfg_rdata1, 32'h0);
        cfg_addr = 8'h84; #1; chk("R13 out1", cfg_rdata1, 32'h0);
        cfg_addr = 8'h10; #1; chk("R13 status", cfg_rdata1, 32'h1);

        finish_run();
    end
endmodule